// File: doc/BRIEF.md
# Dual-Mode Serial PCM Port

This block moves voice samples between two serial lines and a parallel word interface. One serial input line and one serial output line each carry two time-multiplexed channels, A and B. Received bits are assembled into per-channel words and presented on a parallel bus. Parallel words supplied for each channel are shifted out on the serial output. A word is either an 8-bit companded sample or a 16-bit two's-complement linear sample, chosen by a format input. Companding and any signal processing happen elsewhere.

Two framing schemes are supported. In strobe framing, each channel has its own active-high enable strobe, synchronous with a bit clock of 128 kHz to 4.096 MHz. The strobe lasts one word and repeats once per 125 µs frame. In backplane framing, a 4.096 MHz clock and a low-going frame pulse define a frame of 8-bit timeslots. Channel A owns slots 0 and 1, and channel B owns slots 2 and 3. A delayed frame pulse is produced after the fourth slot so that further devices can be chained. The frame-pulse input also selects the scheme: tied low, the port uses strobes; seen high, it uses backplane framing.

All serial inputs are brought into the system clock domain through a synchroniser, and bit-clock edges are detected there. The system clock must therefore run well above the bit clock.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset the port is in strobe framing. The first system-clock sample of the frame-pulse input at 1 switches it to backplane framing, which then holds until the next reset.
- R2: In strobe framing, a channel captures the serial input on each falling bit-clock edge while its strobe is high, most significant bit first. After the last bit of a word, rx_valid pulses for one cycle with rx_chan (0 = A, 1 = B) and rx_data.
- R3: In strobe framing, a channel drives the most significant bit of its word as soon as its strobe goes high. It advances one bit on each later rising bit-clock edge, and the serial output changes only next to a rising bit-clock edge. The word is taken from tx_words while the strobe is low.
- R4: sout_oe is high exactly while some channel is active, and sout is 0 while sout_oe is low.
- R5: With lin16 = 0 a word is 8 bits. Received bytes appear in rx_data[7:0] with the upper byte zero, and transmit bytes come from tx_words[c][7:0]. With lin16 = 1 a word is 16 bits.
- R6: In backplane framing, a frame-pulse low seen at a falling bit-clock edge makes the next bit period bit 0 of the frame. Channel A then occupies bits 0 onward and channel B bits 16 onward, each for one word length (an 8-bit word uses the first slot of its pair), MSB first.
- R7: In backplane framing, dfp_n is low only during frame bit 32, the first bit after slot 3, and high otherwise. In strobe framing it is held low.
- R8: In backplane framing, the strobe inputs have no effect on the serial output or on received words.
- R9: If both channels are active together, sout carries channel A. If both complete a word on the same edge, only channel A's word is reported.
- R10: rx_valid is never high in two consecutive cycles. At reset, rx_valid, sout_oe and dfp_n are all 0.
- R11: A strobe that ends before a full word discards the partial word. No rx_valid results, and the next strobe starts from the first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Serial bit clock |
| fp_n | input | 1 | Frame pulse, active low; tied low selects strobe framing |
| chan_stb | input | 2 | Per-channel enable strobes, bit 0 = A, bit 1 = B |
| sin | input | 1 | Serial input line |
| lin16 | input | 1 | 1 = 16-bit linear words, 0 = 8-bit companded words |
| tx_words | input | 2x16 | Words to transmit, index 0 = A, index 1 = B |
| sout | output | 1 | Serial output line |
| sout_oe | output | 1 | Output enable for sout; low means high impedance |
| dfp_n | output | 1 | Delayed frame pulse for chaining |
| rx_valid | output | 1 | One-cycle pulse for a received word |
| rx_chan | output | 1 | Channel of the received word |
| rx_data | output | 16 | Received word |

## Verification
Two events can fall in the same cycle: channel A releasing the output line and channel B taking it over. This is provoked by placing B's strobe directly after A's, so that on one rising bit-clock edge the first channel's strobe drops and the next rises. Every bit period is compared against a behavioural model to confirm that the line enable stays high, B's MSB appears at once, and both words are received intact. A second collision is forced by raising both strobes together. There the model expects channel A on the line and only A's completed word on the parallel bus.

// File: rtl/pcm_port_pkg.sv
`timescale 1ns/1ps
package pcm_port_pkg;
    localparam int NUM_CH       = 2;
    localparam int WORD_BITS    = 16;
    localparam int BYTE_BITS    = 8;
    localparam int CH_IDX_W     = $clog2(NUM_CH);

    typedef enum logic {
        MODE_STROBE    = 1'b0,
        MODE_BACKPLANE = 1'b1
    } port_mode_e;

    // raw serial-side inputs, bclk kept as the MSB
    typedef struct packed {
        logic              bclk;
        logic              fp_n;
        logic              din;
        logic [NUM_CH-1:0] stb;
    } line_in_t;

    localparam int LINE_W = $bits(line_in_t);

    // word to load into the transmit shifter, MSB aligned
    function automatic logic [WORD_BITS-1:0] tx_align(input logic wide,
                                                      input logic [WORD_BITS-1:0] w);
        return wide ? w : {w[BYTE_BITS-1:0], {(WORD_BITS-BYTE_BITS){1'b0}}};
    endfunction

    // assembled receive word, right aligned for bytes
    function automatic logic [WORD_BITS-1:0] rx_align(input logic wide,
                                                      input logic [WORD_BITS-1:0] sh);
        return wide ? sh : {{(WORD_BITS-BYTE_BITS){1'b0}}, sh[BYTE_BITS-1:0]};
    endfunction

    function automatic int word_len(input logic wide);
        return wide ? WORD_BITS : BYTE_BITS;
    endfunction
endpackage

// File: rtl/pcm_edge_sync.sv
`timescale 1ns/1ps
module pcm_edge_sync #(
    parameter int WIDTH   = 5,
    parameter int STAGES  = 2,
    parameter int CLK_IDX = WIDTH - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced,
    output logic             rise_ev,
    output logic             fall_ev
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;
    logic                         clk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe  <= '0;
            clk_d <= 1'b0;
        end else begin
            pipe[0] <= raw;
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
            clk_d <= pipe[STAGES-1][CLK_IDX];
        end
    end

    assign synced  = pipe[STAGES-1];
    assign rise_ev = synced[CLK_IDX] & ~clk_d;
    assign fall_ev = ~synced[CLK_IDX] & clk_d;
endmodule

// File: rtl/pcm_frame_ctl.sv
`timescale 1ns/1ps
module pcm_frame_ctl
    import pcm_port_pkg::*;
#(
    parameter int SLOT_BITS    = BYTE_BITS,
    parameter int FRAME_SLOTS  = 32,
    parameter int SLOTS_PER_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_ev,
    input  logic              fall_ev,
    input  logic              fp_s,
    input  logic [NUM_CH-1:0] stb_s,
    input  logic              lin16,
    output port_mode_e        mode,
    output logic [NUM_CH-1:0] act,
    output logic              dfp_n
);
    localparam int FRAME_BITS = FRAME_SLOTS * SLOT_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int CH_SPAN    = SLOTS_PER_CH * SLOT_BITS;
    localparam int DFP_POS    = NUM_CH * CH_SPAN;
    localparam logic [POS_W-1:0] POS_MAX = POS_W'(FRAME_BITS - 1);

    logic [POS_W-1:0] pos;
    logic             pend;
    logic             synced;
    int               wlen;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= MODE_STROBE;
            pos    <= '0;
            pend   <= 1'b0;
            synced <= 1'b0;
        end else begin
            if (fp_s) mode <= MODE_BACKPLANE;
            if (mode == MODE_BACKPLANE && fall_ev && !fp_s) pend <= 1'b1;
            if (rise_ev) begin
                if (pend) begin
                    pos    <= '0;
                    synced <= 1'b1;
                    pend   <= 1'b0;
                end else if (synced && pos != POS_MAX) begin
                    pos <= pos + 1'b1;
                end
            end
        end
    end

    assign wlen = word_len(lin16);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_win
        localparam int BASE = c * CH_SPAN;
        logic in_win;
        assign in_win = synced && (int'(pos) >= BASE) && (int'(pos) < BASE + wlen);
        assign act[c] = (mode == MODE_BACKPLANE) ? in_win : stb_s[c];
    end

    assign dfp_n = (mode == MODE_BACKPLANE) ? !(synced && int'(pos) == DFP_POS) : 1'b0;
endmodule

// File: rtl/pcm_chan_lane.sv
`timescale 1ns/1ps
module pcm_chan_lane
    import pcm_port_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rise_ev,
    input  logic                 fall_ev,
    input  logic                 act,
    input  logic                 sin,
    input  logic                 lin16,
    input  logic [WORD_BITS-1:0] tx_word,
    output logic                 tx_bit,
    output logic                 rx_done,
    output logic [WORD_BITS-1:0] rx_word
);
    localparam int CNT_W = $clog2(WORD_BITS);
    localparam logic [CNT_W-1:0] LAST_WIDE = CNT_W'(WORD_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(BYTE_BITS - 1);

    logic                 act_d;
    logic [WORD_BITS-1:0] txsh;
    logic [WORD_BITS-1:0] rxsh;
    logic [WORD_BITS-1:0] rx_next;
    logic [CNT_W-1:0]     cnt;
    logic [CNT_W-1:0]     last;

    assign last    = lin16 ? LAST_WIDE : LAST_BYTE;
    assign rx_next = {rxsh[WORD_BITS-2:0], sin};

    always_ff @(posedge clk) begin
        if (rst) begin
            act_d   <= 1'b0;
            txsh    <= '0;
            rxsh    <= '0;
            cnt     <= '0;
            rx_done <= 1'b0;
            rx_word <= '0;
        end else begin
            act_d   <= act;
            rx_done <= 1'b0;
            // transmit: hold the next word while idle, shift on later rising edges
            if (!act) begin
                txsh <= tx_align(lin16, tx_word);
            end else if (rise_ev && act_d) begin
                txsh <= {txsh[WORD_BITS-2:0], 1'b0};
            end
            // receive: count only inside the active window
            if (!act) begin
                cnt <= '0;
            end else if (fall_ev) begin
                rxsh <= rx_next;
                if (cnt == last) begin
                    rx_done <= 1'b1;
                    rx_word <= rx_align(lin16, rx_next);
                    cnt     <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign tx_bit = txsh[WORD_BITS-1];
endmodule

// File: rtl/pcm_serial_port.sv
`timescale 1ns/1ps
module pcm_serial_port
    import pcm_port_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int FRAME_SLOTS  = 32,
    parameter int SLOTS_PER_CH = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             bclk,
    input  logic                             fp_n,
    input  logic [NUM_CH-1:0]                chan_stb,
    input  logic                             sin,
    input  logic                             lin16,
    input  logic [NUM_CH-1:0][WORD_BITS-1:0] tx_words,
    output logic                             sout,
    output logic                             sout_oe,
    output logic                             dfp_n,
    output logic                             rx_valid,
    output logic [CH_IDX_W-1:0]              rx_chan,
    output logic [WORD_BITS-1:0]             rx_data
);
    line_in_t                         line_raw;
    line_in_t                         line_s;
    logic                             rise_ev;
    logic                             fall_ev;
    port_mode_e                       mode;
    logic                             bp_mode;
    logic [NUM_CH-1:0]                act;
    logic [NUM_CH-1:0]                tx_bits;
    logic [NUM_CH-1:0]                rx_done;
    logic [NUM_CH-1:0][WORD_BITS-1:0] rx_words;

    assign line_raw = '{bclk: bclk, fp_n: fp_n, din: sin, stb: chan_stb};

    pcm_edge_sync #(
        .WIDTH  (LINE_W),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst     (rst),
        .raw     (line_raw),
        .synced  (line_s),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    pcm_frame_ctl #(
        .SLOT_BITS    (BYTE_BITS),
        .FRAME_SLOTS  (FRAME_SLOTS),
        .SLOTS_PER_CH (SLOTS_PER_CH)
    ) i_frame (
        .clk     (clk),
        .rst     (rst),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev),
        .fp_s    (line_s.fp_n),
        .stb_s   (line_s.stb),
        .lin16   (lin16),
        .mode    (mode),
        .act     (act),
        .dfp_n   (dfp_n)
    );

    assign bp_mode = (mode == MODE_BACKPLANE);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        pcm_chan_lane i_lane (
            .clk     (clk),
            .rst     (rst),
            .rise_ev (rise_ev),
            .fall_ev (fall_ev),
            .act     (act[c]),
            .sin     (line_s.din),
            .lin16   (lin16),
            .tx_word (tx_words[c]),
            .tx_bit  (tx_bits[c]),
            .rx_done (rx_done[c]),
            .rx_word (rx_words[c])
        );
    end

    // lowest-numbered channel wins on both the line and the word bus
    always_comb begin
        sout     = 1'b0;
        rx_chan  = '0;
        rx_data  = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (act[c]) sout = tx_bits[c];
            if (rx_done[c]) begin
                rx_chan = CH_IDX_W'(c);
                rx_data = rx_words[c];
            end
        end
    end

    assign sout_oe  = |act;
    assign rx_valid = |rx_done;
endmodule

// File: rtl/pcm_serial_port_chk.sv
`timescale 1ns/1ps
module pcm_serial_port_chk (
    input logic clk,
    input logic rst,
    input logic bp_mode,
    input logic rise_ev,
    input logic fall_ev,
    input logic rx_valid,
    input logic sout,
    input logic sout_oe,
    input logic dfp_n
);
    // R1
    mode_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        bp_mode |=> bp_mode);

    // R2
    rx_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(fall_ev));

    // R3
    sout_timing_chk: assert property (@(posedge clk) disable iff (rst)
        $changed(sout) |-> (rise_ev || $past(rise_ev)));

    // R4
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        !sout_oe |-> !sout);

    // R7
    dfp_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (bp_mode && $fell(dfp_n)) |-> $past(rise_ev));

    // R10
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
endmodule

bind pcm_serial_port pcm_serial_port_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .bp_mode  (bp_mode),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev),
    .rx_valid (rx_valid),
    .sout     (sout),
    .sout_oe  (sout_oe),
    .dfp_n    (dfp_n)
);

// File: tb/test_pcm_serial_port.sv
`timescale 1ns/1ps
module test_pcm_serial_port;
    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bclk = 1'b0;
    logic            fp_n = 1'b0;
    logic [1:0]      chan_stb = 2'b00;
    logic            sin = 1'b0;
    logic            lin16 = 1'b0;
    logic [1:0][15:0] tx_words = '0;
    logic            sout, sout_oe, dfp_n, rx_valid;
    logic [0:0]      rx_chan;
    logic [15:0]     rx_data;

    int n_chk = 0;
    int n_fail = 0;

    // behavioural model state
    bit         m_bp, m_pend, m_sync;
    int         m_pos;
    int         m_idx [2];
    bit         m_prev [2];
    bit         m_act [2];
    int         m_cnt [2];
    logic [15:0] m_sh [2];
    logic [16:0] exp_q [$];
    logic [16:0] got_q [$];
    bit         prev_v;
    string      sout_tag = "R3";

    always #5 clk = ~clk;

    pcm_serial_port i_pcm_serial_port (
        .clk(clk), .rst(rst), .bclk(bclk), .fp_n(fp_n), .chan_stb(chan_stb),
        .sin(sin), .lin16(lin16), .tx_words(tx_words), .sout(sout),
        .sout_oe(sout_oe), .dfp_n(dfp_n), .rx_valid(rx_valid),
        .rx_chan(rx_chan), .rx_data(rx_data)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] actual, input logic [31:0] expected);
        n_chk++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, actual, expected);
        end
    endtask

    // R10: single-cycle pulse; collect received words
    always @(negedge clk) begin
        if (rst) begin
            prev_v = 1'b0;
        end else begin
            if (rx_valid) begin
                chk("R10", "rx_valid repeat", {31'b0, prev_v}, 32'd0);
                got_q.push_back({rx_chan, rx_data});
            end
            prev_v = rx_valid;
        end
    end

    function automatic int wl();
        return lin16 ? 16 : 8;
    endfunction

    task automatic do_reset();
        rst = 1'b1; bclk = 1'b0; fp_n = 1'b0; chan_stb = 2'b00; sin = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        m_bp = 0; m_pend = 0; m_sync = 0; m_pos = 0; prev_v = 0;
        for (int c = 0; c < 2; c++) begin
            m_idx[c] = 0; m_prev[c] = 0; m_cnt[c] = 0; m_sh[c] = '0;
        end
        exp_q.delete(); got_q.delete();
        repeat (3) @(negedge clk);
    endtask

    // one bit period: rising half then falling half, 8 system cycles each
    task automatic bitp(input logic [1:0] s, input logic f, input logic d);
        logic e_so, e_oe, e_dfp;
        bit   done;
        bclk = 1'b1; chan_stb = s; fp_n = f; sin = d;
        if (f) m_bp = 1;
        if (m_bp) begin
            if (m_pend) begin m_pos = 0; m_sync = 1; m_pend = 0; end
            else if (m_sync && m_pos < 255) m_pos++;
        end
        for (int c = 0; c < 2; c++) begin
            m_act[c] = m_bp ? (m_sync && m_pos >= 16*c && m_pos < 16*c + wl()) : s[c];
            if (m_act[c]) m_idx[c] = m_bp ? (m_pos - 16*c) : (m_prev[c] ? m_idx[c] + 1 : 0);
            m_prev[c] = m_act[c];
        end
        repeat (8) @(negedge clk);
        e_oe = m_act[0] | m_act[1];
        e_so = m_act[0] ? tx_words[0][wl()-1-m_idx[0]] :
               m_act[1] ? tx_words[1][wl()-1-m_idx[1]] : 1'b0;
        e_dfp = m_bp ? !(m_sync && m_pos == 32) : 1'b0;
        chk(sout_tag, "sout", {31'b0, sout}, {31'b0, e_so});
        chk("R4", "sout_oe", {31'b0, sout_oe}, {31'b0, e_oe});
        chk("R7", "dfp_n", {31'b0, dfp_n}, {31'b0, e_dfp});
        bclk = 1'b0;
        if (m_bp && !f) m_pend = 1;
        done = 0;
        for (int c = 0; c < 2; c++) begin
            if (m_act[c]) begin
                m_sh[c] = {m_sh[c][14:0], d};
                m_cnt[c]++;
                if (m_cnt[c] == wl()) begin
                    m_cnt[c] = 0;
                    // R9: lower channel reported when both finish together
                    if (!done) exp_q.push_back({1'(c), (wl() == 16) ? m_sh[c] : {8'h00, m_sh[c][7:0]}});
                    done = 1;
                end
            end else begin
                m_cnt[c] = 0;
            end
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic cmp_rx(input string tag);
        chk(tag, "word count", got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk(tag, "rx word", {15'b0, got_q[i]}, {15'b0, exp_q[i]});
        exp_q.delete(); got_q.delete();
    endtask

    function automatic logic rbit();
        return 1'($urandom % 2);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R10: reset state
        chk("R10", "rx_valid at reset", {31'b0, rx_valid}, 32'd0);
        chk("R10", "sout_oe at reset", {31'b0, sout_oe}, 32'd0);
        chk("R10", "dfp_n at reset", {31'b0, dfp_n}, 32'd0);

        // R5: strobe framing, 8-bit words with gaps
        lin16 = 1'b0; tx_words[0] = 16'h77A5; tx_words[1] = 16'h113C; sout_tag = "R5";
        repeat (2) bitp(2'b00, 1'b0, 1'b0);
        repeat (8) bitp(2'b01, 1'b0, rbit());
        repeat (2) bitp(2'b00, 1'b0, rbit());
        repeat (8) bitp(2'b10, 1'b0, rbit());
        repeat (2) bitp(2'b00, 1'b0, 1'b0);
        cmp_rx("R5");

        // R2 / R3: 16-bit, B strobe directly after A (hand-over)
        lin16 = 1'b1; tx_words[0] = 16'hC3A1; tx_words[1] = 16'h5E0F; sout_tag = "R3";
        bitp(2'b00, 1'b0, 1'b0);
        repeat (16) bitp(2'b01, 1'b0, rbit());
        repeat (16) bitp(2'b10, 1'b0, rbit());
        repeat (2) bitp(2'b00, 1'b0, 1'b0);
        cmp_rx("R2");

        // R11: short strobe then a full one
        repeat (5) bitp(2'b01, 1'b0, rbit());
        repeat (3) bitp(2'b00, 1'b0, 1'b0);
        cmp_rx("R11");
        repeat (16) bitp(2'b01, 1'b0, rbit());
        bitp(2'b00, 1'b0, 1'b0);
        cmp_rx("R11");

        // R9: overlapping strobes
        tx_words[0] = 16'h9F30; tx_words[1] = 16'h0FF0; sout_tag = "R9";
        repeat (16) bitp(2'b11, 1'b0, rbit());
        repeat (2) bitp(2'b00, 1'b0, 1'b0);
        cmp_rx("R9");

        // R1 / R6 / R7: backplane framing, 16-bit words
        do_reset();
        lin16 = 1'b1; tx_words[0] = 16'hB2D4; tx_words[1] = 16'h6A19; sout_tag = "R6";
        repeat (3) bitp(2'b00, 1'b1, 1'b0);
        chk("R1", "backplane idle dfp_n", {31'b0, dfp_n}, 32'd1);
        bitp(2'b00, 1'b0, 1'b0);
        repeat (40) bitp(2'b00, 1'b1, rbit());
        cmp_rx("R6");

        // R8: second frame, 8-bit words, strobes toggling
        lin16 = 1'b0; tx_words[0] = 16'h00E7; tx_words[1] = 16'h0058; sout_tag = "R8";
        bitp(2'b11, 1'b0, 1'b0);
        repeat (40) bitp(2'($urandom % 4), 1'b1, rbit());
        cmp_rx("R8");
        chk("R1", "mode held after frame pulse", {31'b0, dfp_n}, 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule